// File: doc/BRIEF.md
# Key-Protected Register Write Lock

This block sits on the write side of a peripheral's register bus, between the bus and the register file. It decides, for each write, whether the register file may accept it. It owns two registers of its own. The lock-mode register holds a single protection-enable bit. That bit changes only when the same write carries a fixed 24-bit key in its upper bits.

While protection is on, writes to the clock-mode and frame-mode registers are refused. By default these registers occupy a configurable offset window. The block records each refused write in a sticky violation flag, together with the register offset that was targeted. Writes to the control, data and interrupt registers lie outside the window and always pass. Software reads the lock-status register to learn what was blocked, and that read clears the record.

Top module: `wr_lock_guard`

## Requirements
- R1: After reset, protection is off, and both the lock-mode register and the lock-status register read as zero.
- R2: A write to the lock-mode register (default offset 0x40) whose bits 31:8 equal 0x535343 loads write-data bit 0 into the protection-enable bit. The new bit value shows on a read from the next cycle on.
- R3: A write to the lock-mode register with any other value in bits 31:8 leaves the protection-enable bit unchanged.
- R4: A read of the lock-mode register returns the enable bit in bit 0, and zero in bits 31:1. In particular the key field always reads as zero.
- R5: While protection is on, a write whose offset lies in the protected window (default 0x04 to 0x1C inclusive) has `wr_allow` low in the same cycle.
- R6: A write outside the protected window, or any write while protection is off, has `wr_allow` high in the same cycle. This excludes writes to the block's own two registers.
- R7: A blocked write sets the violation flag (lock-status bit 0). It also loads its offset, zero-extended to 16 bits, into lock-status bits 23:8. Both are visible from the next cycle.
- R8: A read of the lock-status register (default offset 0x44) returns the current contents and clears the flag and the source field in the next cycle.
- R9: If a blocked write arrives in the same cycle as a lock-status read, the new violation is kept: the flag is set and the source holds the new offset.
- R10: Writes to the lock-mode or lock-status offsets never raise `wr_allow`. A write to the lock-status offset has no effect on its contents.
- R11: A later blocked write overwrites the source field with its own offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Byte offset of the read |
| wr_allow | output | 1 | Write may be committed to the register file |
| rd_data | output | 32 | Read data for the lock-mode and lock-status offsets, zero otherwise |

## Verification
Several rules are checked by assertions on every cycle:
- a keyed write updates the enable bit and an unkeyed one keeps it stable;
- a blocked write always leaves the flag set with its offset in the source field, whether or not a status read collides with it;
- a status read without a collision empties the record;
- mode readback never exposes the key.

The same-cycle view of `wr_allow` across the window edges and the guard offsets can only be shown by the bench's scenarios. So can the overwrite order of successive violations and the exact values that software would read.

// File: rtl/wr_lock_guard.sv
`timescale 1ns/1ps
module wr_lock_guard #(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 16,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h44,
  parameter logic [ADDR_W-1:0] PROT_LO  = 8'h04,
  parameter logic [ADDR_W-1:0] PROT_HI  = 8'h1C,
  parameter logic [23:0]       KEY      = 24'h535343
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_allow,
  output logic [31:0]       rd_data
);
  localparam int PAD_HI = 32 - 8 - SRC_W;

  logic              lock_q;
  logic              viol_q;
  logic [SRC_W-1:0]  src_q;

  wire mode_wr  = wr_en && (wr_addr == MODE_OFS);
  wire key_ok   = (wr_data[31:8] == KEY);
  wire in_win   = (wr_addr >= PROT_LO) && (wr_addr <= PROT_HI);
  wire own_reg  = (wr_addr == MODE_OFS) || (wr_addr == STAT_OFS);
  wire blocked  = wr_en && lock_q && in_win;
  wire stat_rd  = rd_en && (rd_addr == STAT_OFS);

  assign wr_allow = wr_en && !own_reg && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      viol_q <= 1'b0;
      src_q  <= '0;
    end else begin
      if (mode_wr && key_ok)
        lock_q <= wr_data[0];
      if (blocked) begin
        viol_q <= 1'b1;
        src_q  <= SRC_W'(wr_addr);
      end else if (stat_rd) begin
        viol_q <= 1'b0;
        src_q  <= '0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && rd_addr == MODE_OFS)
      rd_data = {31'b0, lock_q};
    else if (stat_rd)
      rd_data = {{PAD_HI{1'b0}}, src_q, 7'b0, viol_q};
  end

  // R2
  key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MODE_OFS && wr_data[31:8] == KEY) |=> (lock_q == $past(wr_data[0])));

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MODE_OFS && wr_data[31:8] != KEY) |=> $stable(lock_q));

  // R4
  mode_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == MODE_OFS) |-> (rd_data[31:1] == '0));

  // R7 R9
  viol_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_q && wr_addr >= PROT_LO && wr_addr <= PROT_HI)
      |=> (viol_q && src_q == SRC_W'($past(wr_addr))));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == STAT_OFS && !(wr_en && lock_q && wr_addr >= PROT_LO && wr_addr <= PROT_HI))
      |=> (!viol_q && src_q == '0));

  // R5
  win_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow && lock_q) |-> !(wr_addr >= PROT_LO && wr_addr <= PROT_HI));
endmodule

// File: tb/wr_lock_guard_tb_top.sv
`timescale 1ns/1ps
module wr_lock_guard_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic        wr_allow;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  localparam logic [7:0] MODE = 8'h40, STAT = 8'h44;
  localparam logic [23:0] KEY = 24'h535343;

  always #2.5 clk = ~clk;

  wr_lock_guard dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .wr_allow(wr_allow), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                     input logic re, input logic [7:0] ra,
                     output logic allow, output logic [31:0] rdat);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    #1;
    allow = wr_allow; rdat = rd_data;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic allow);
    logic [31:0] unused;
    cyc(1'b1, a, d, 1'b0, 8'h00, allow, unused);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    logic unused;
    cyc(1'b0, 8'h00, 32'h0, 1'b1, a, unused, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(MODE, d); chk("R1 mode after reset", d, 32'h0);
    rd(STAT, d); chk("R1 status after reset", d, 32'h0);
  endtask

  task automatic t_key;
    logic a; logic [31:0] d;
    wr(MODE, {KEY, 8'h01}, a); chk("R10 mode write not forwarded", a, 0);
    rd(MODE, d); chk("R2 R4 keyed enable reads 1", d, 32'h1);
    wr(MODE, {24'h123456, 8'h00}, a);
    rd(MODE, d); chk("R3 bad key keeps enable", d, 32'h1);
    wr(MODE, {24'h535342, 8'hFE}, a);
    rd(MODE, d); chk("R3 R4 near key ignored, key reads zero", d, 32'h1);
    wr(MODE, {KEY, 8'h00}, a);
    rd(MODE, d); chk("R2 keyed disable reads 0", d, 32'h0);
  endtask

  task automatic t_block;
    logic a; logic [31:0] d;
    wr(MODE, {KEY, 8'h01}, a);
    wr(8'h10, 32'hAAAA, a); chk("R5 window write blocked", a, 0);
    wr(8'h04, 32'h1, a);    chk("R5 window low edge blocked", a, 0);
    wr(8'h00, 32'h1, a);    chk("R6 control write passes", a, 1);
    wr(8'h20, 32'h1, a);    chk("R6 above window passes", a, 1);
    rd(STAT, d); chk("R7 R11 status after blocks", d, 32'h0000_0401);
    rd(STAT, d); chk("R8 status cleared by read", d, 32'h0);
  endtask

  task automatic t_overwrite;
    logic a; logic [31:0] d;
    wr(8'h1C, 32'h0, a); chk("R5 window high edge blocked", a, 0);
    wr(8'h18, 32'h0, a);
    rd(STAT, d); chk("R11 latest source kept", d, 32'h0000_1801);
  endtask

  task automatic t_race;
    logic a; logic [31:0] d;
    cyc(1'b1, 8'h14, 32'h0, 1'b1, STAT, a, d);
    chk("R8 read returns prior state", d, 32'h0);
    chk("R5 colliding write blocked", a, 0);
    rd(STAT, d); chk("R9 violation wins over clear", d, 32'h0000_1401);
  endtask

  task automatic t_guard;
    logic a; logic [31:0] d;
    wr(8'h0C, 32'h0, a);
    wr(STAT, 32'h0, a); chk("R10 status write not forwarded", a, 0);
    rd(STAT, d); chk("R10 status write has no effect", d, 32'h0000_0C01);
  endtask

  task automatic t_unlock;
    logic a; logic [31:0] d;
    wr(MODE, {KEY, 8'h00}, a);
    wr(8'h10, 32'h5, a); chk("R6 window passes when off", a, 1);
    rd(STAT, d); chk("R6 no violation when off", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_key;
    t_block;
    t_overwrite;
    t_race;
    t_guard;
    t_unlock;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule